// File: doc/BRIEF.md
# ATA Programmed-I/O Strobe Timer

This block runs legacy ATA programmed-I/O register cycles for one channel that carries two drives. The host issues a request with a one-clock pulse on `req_valid`. The request carries a register address, a direction, a drive number and write data. The block then drives the read or write strobe toward the device and samples the device's ready line. It returns read data together with a one-clock `done` pulse.

All timing is counted in host clocks. Two numbers set the shape of each cycle:

- The sample point is the number of clocks from strobe assertion to the first ready sample.
- The recovery time is the minimum number of clocks from the last ready sample to the end of the cycle.

Both numbers come from a 16-bit timing word, a 4-bit separate timing value for drive 1, or a fixed compatible setting. Per-drive enable bits in the timing word choose among these sources.

The address has 4 bits. When bit 3 is 0, bits 2:0 select a command-block register, and offset 0 is the data port. When bit 3 is 1, the access goes to the control block. The address and the write data are held steady on the device side for the whole cycle.

Top module: `ide_pio_timer`

## Requirements
- R1: After reset both strobes (`dev_ior_n`, `dev_iow_n`) are high, `done` is low, `claimed` is low and `rd_data` is zero.
- R2: Compatible timing is a 5-clock sample point and a 4-clock recovery. The strobe is low for 5 clocks, and `done` rises 4 clocks after the strobe rises. This timing is used for drive 0 when bit 0 of `tim_reg` is 0, and for drive 1 when bit 4 is 0.
- R3: Fast timing applies to a data-port access when the drive's fast bit is 1. The sample point comes from `tim_reg[13:12]`, encoded 00=5, 01=4, 10=3, with the reserved code 11 acting as 5. The recovery comes from `tim_reg[9:8]`, encoded 00=4, 01=3, 10=2, 11=1.
- R4: For drive 1 with fast timing, `tim_reg[14]`=0 uses the shared fields. `tim_reg[14]`=1 uses `slv_tim[3:2]` as the sample code and `slv_tim[1:0]` as the recovery code, with the same encodings.
- R5: A drive whose DMA-only bit is set uses compatible timing for PIO data-port accesses, even when its fast bit is 1. The DMA-only bit is `tim_reg[3]` for drive 0 and `tim_reg[7]` for drive 1.
- R6: Any access that is not to the data port always uses compatible timing. This covers command offsets 1 to 7 and every control-block access.
- R7: The ready-enable bit is `tim_reg[1]` for drive 0 and `tim_reg[5]` for drive 1.
  - When the bit is 1, a low `dev_iordy` at the sample point keeps the strobe asserted. The line is resampled every clock, and the strobe rises on the first clock it is sampled high.
  - When the bit is 0, `dev_iordy` is ignored and the strobe ends at the sample point.
- R8: When `tim_reg[15]` is 0, a request asserts no strobe. `done` pulses one clock after the request with `claimed`=0.
- R9: A read asserts only `dev_ior_n` and captures `dev_rdata` into `rd_data` on the clock the strobe rises. A write asserts only `dev_iow_n` and holds `req_wdata` on `dev_wdata` and the address on `dev_addr`.
- R10: `done` is a single-clock pulse that arrives only after the recovery count has run out. `claimed` is 1 with `done` for every decoded cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tim_reg | input | 16 | Channel timing word |
| slv_tim | input | 4 | Separate drive-1 sample and recovery codes |
| req_valid | input | 1 | One-clock request pulse, taken when idle |
| req_addr | input | 4 | Register address (bit 3 selects the control block) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_drive | input | 1 | Drive number |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | Cycle complete pulse |
| claimed | output | 1 | Valid with done: 1 if the cycle was decoded |
| dev_ior_n | output | 1 | Read strobe, active low |
| dev_iow_n | output | 1 | Write strobe, active low |
| dev_addr | output | 4 | Address toward the device |
| dev_wdata | output | 16 | Write data toward the device |
| dev_rdata | input | 16 | Read data from the device |
| dev_iordy | input | 1 | Device ready |

## Verification
The strobe falls one clock after the request pulse. It stays low for exactly the sample-point count plus one clock for each low ready sample. `done` rises exactly the recovery count of clocks after the strobe rises. A cycle on a disabled channel gives `done` one clock after the request. The bench samples at falling edges and, in each scenario task, counts how many of those samples see the strobe low and how many see it high before `done`. It compares both counts with the values it expects from the field encodings. It programs `dev_iordy` per falling edge, so a set number of low samples lands on exactly the edges where the design samples the line.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

    localparam int CNT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_RECOV  = 2'd2
    } pio_state_e;

    // Sample code to clocks: 00->5, 01->4, 10->3, 11 (reserved)->5
    function automatic logic [CNT_W-1:0] sample_clks(input logic [1:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            2'b01:   r = CNT_W'(4);
            2'b10:   r = CNT_W'(3);
            default: r = CNT_W'(5);
        endcase
        return r;
    endfunction

    // Recovery code to clocks: 00->4 down to 11->1
    function automatic logic [CNT_W-1:0] recov_clks(input logic [1:0] code);
        return CNT_W'(4) - CNT_W'(code);
    endfunction

endpackage

// File: rtl/ide_timing_sel.sv
module ide_timing_sel
    import ide_pio_pkg::*;
#(
    parameter int TREG_W = 16,
    parameter int ADDR_W = 4,
    parameter int COMPAT_SAMPLE = 5,
    parameter int COMPAT_RECOV = 4
) (
    input  logic [TREG_W-1:0] tim_reg,
    input  logic [3:0]        slv_tim,
    input  logic              drive,
    input  logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  sample_clks_o,
    output logic [CNT_W-1:0]  recov_clks_o,
    output logic              iordy_en_o
);
    localparam logic [ADDR_W-1:0] DATA_PORT = '0;

    logic is_data;
    logic fast;
    logic use_slave;
    logic [1:0] s_code;
    logic [1:0] r_code;

    always_comb begin
        is_data   = (addr == DATA_PORT);
        fast      = drive ? (tim_reg[4] && !tim_reg[7]) : (tim_reg[0] && !tim_reg[3]);
        use_slave = drive && tim_reg[14];
        s_code    = use_slave ? slv_tim[3:2] : tim_reg[13:12];
        r_code    = use_slave ? slv_tim[1:0] : tim_reg[9:8];
        if (fast && is_data) begin
            sample_clks_o = sample_clks(s_code);
            recov_clks_o  = recov_clks(r_code);
        end else begin
            sample_clks_o = CNT_W'(COMPAT_SAMPLE);
            recov_clks_o  = CNT_W'(COMPAT_RECOV);
        end
        iordy_en_o = drive ? tim_reg[5] : tim_reg[1];
    end

    // R3
    always_comb begin
        sample_range_chk: assert (sample_clks_o >= CNT_W'(3) && sample_clks_o <= CNT_W'(5));
    end

    // R3
    always_comb begin
        recov_range_chk: assert (recov_clks_o >= CNT_W'(1) && recov_clks_o <= CNT_W'(4));
    end

endmodule

// File: rtl/ide_pio_fsm.sv
module ide_pio_fsm
    import ide_pio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  sample_clks_i,
    input  logic [CNT_W-1:0]  recov_clks_i,
    input  logic              iordy_en_i,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              dev_iordy,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              claimed,
    output logic              dev_ior_n,
    output logic              dev_iow_n,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_wdata
);
    typedef struct packed {
        pio_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  rec;
        logic              ie;
        logic              write;
        logic              ior_n;
        logic              iow_n;
        logic              done;
        logic              claimed;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } fsm_t;

    localparam fsm_t FSM_RESET = '{
        st: ST_IDLE, cnt: '0, rec: '0, ie: 1'b0, write: 1'b0,
        ior_n: 1'b1, iow_n: 1'b1, done: 1'b0, claimed: 1'b0,
        addr: '0, wdata: '0, rdata: '0
    };

    fsm_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!dec_en) begin
                        d.done    = 1'b1;
                        d.claimed = 1'b0;
                    end else begin
                        d.st      = ST_STROBE;
                        d.cnt     = sample_clks_i - CNT_W'(1);
                        d.rec     = recov_clks_i - CNT_W'(1);
                        d.ie      = iordy_en_i;
                        d.write   = req_write;
                        d.addr    = req_addr;
                        d.wdata   = req_wdata;
                        d.ior_n   = req_write;
                        d.iow_n   = !req_write;
                        d.claimed = 1'b1;
                    end
                end
            end
            ST_STROBE: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - CNT_W'(1);
                end else if (!q.ie || dev_iordy) begin
                    d.ior_n = 1'b1;
                    d.iow_n = 1'b1;
                    if (!q.write) d.rdata = dev_rdata;
                    d.st  = ST_RECOV;
                    d.cnt = q.rec;
                end
            end
            ST_RECOV: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - CNT_W'(1);
                end else begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d = FSM_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FSM_RESET;
        else        q <= d;
    end

    assign rd_data   = q.rdata;
    assign done      = q.done;
    assign claimed   = q.claimed;
    assign dev_ior_n = q.ior_n;
    assign dev_iow_n = q.iow_n;
    assign dev_addr  = q.addr;
    assign dev_wdata = q.wdata;

    // R9
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ior_n || dev_iow_n);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dev_ior_n && dev_iow_n));

    // R8
    decode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dev_ior_n) || $fell(dev_iow_n)) |-> $past(dec_en));

    // R7
    iordy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_STROBE && q.cnt == '0 && q.ie && !dev_iordy)
            |=> !(dev_ior_n && dev_iow_n));

endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
    import ide_pio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int TREG_W = 16,
    parameter int COMPAT_SAMPLE = 5,
    parameter int COMPAT_RECOV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TREG_W-1:0] tim_reg,
    input  logic [3:0]        slv_tim,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_drive,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              claimed,
    output logic              dev_ior_n,
    output logic              dev_iow_n,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              dev_iordy
);
    logic [CNT_W-1:0] sel_sample;
    logic [CNT_W-1:0] sel_recov;
    logic             sel_ie;
    logic             unused_bits;

    assign unused_bits = ^{tim_reg[11:10], tim_reg[6], tim_reg[2]};

    ide_timing_sel #(
        .TREG_W(TREG_W), .ADDR_W(ADDR_W),
        .COMPAT_SAMPLE(COMPAT_SAMPLE), .COMPAT_RECOV(COMPAT_RECOV)
    ) u_sel (
        .tim_reg(tim_reg), .slv_tim(slv_tim), .drive(req_drive), .addr(req_addr),
        .sample_clks_o(sel_sample), .recov_clks_o(sel_recov), .iordy_en_o(sel_ie)
    );

    ide_pio_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .dec_en(tim_reg[15]),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .sample_clks_i(sel_sample), .recov_clks_i(sel_recov),
        .iordy_en_i(sel_ie), .dev_rdata(dev_rdata), .dev_iordy(dev_iordy),
        .rd_data(rd_data), .done(done), .claimed(claimed),
        .dev_ior_n(dev_ior_n), .dev_iow_n(dev_iow_n),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata)
    );

endmodule

// File: tb/tb_ide_pio_timer.sv
module tb_ide_pio_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tim_reg = '0;
    logic [3:0]  slv_tim = '0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_drive = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rd_data;
    logic        done, claimed, dev_ior_n, dev_iow_n;
    logic [3:0]  dev_addr;
    logic [15:0] dev_wdata;
    logic [15:0] dev_rdata = 16'h0;
    logic        dev_iordy = 1'b1;

    int tests = 0;
    int fails = 0;

    ide_pio_timer dut (
        .clk(clk), .rst_n(rst_n), .tim_reg(tim_reg), .slv_tim(slv_tim),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_drive(req_drive), .req_wdata(req_wdata), .rd_data(rd_data),
        .done(done), .claimed(claimed), .dev_ior_n(dev_ior_n), .dev_iow_n(dev_iow_n),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .dev_iordy(dev_iordy)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Measured results of the last cycle
    int m_width, m_rec, m_claim, m_rdata, m_wdata, m_addr, m_other;

    // hi_at: dev_iordy is high at strobe-clock k when k >= hi_at
    task automatic run(input logic [3:0] a, input logic wr, input logic drv,
                       input logic [15:0] wd, input int hi_at);
        int k;
        m_width = 0; m_rec = 0; m_other = 0; k = 0;
        @(negedge clk);
        req_addr = a; req_write = wr; req_drive = drv; req_wdata = wd;
        req_valid = 1'b1;
        dev_iordy = (hi_at == 0);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (done) begin
                m_claim = int'(claimed);
                m_rdata = int'(rd_data);
                break;
            end
            if (!(wr ? dev_iow_n : dev_ior_n)) begin
                k++;
                m_width++;
                m_wdata = int'(dev_wdata);
                m_addr  = int'(dev_addr);
                dev_iordy = (k >= hi_at);
            end else if (m_width > 0) begin
                m_rec++;
            end
            if (!(wr ? dev_ior_n : dev_iow_n)) m_other++;
            if (i == 99) check("watchdog", 0, 1);
            @(negedge clk);
        end
        dev_iordy = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 ior", int'(dev_ior_n), 1);
        check("R1 iow", int'(dev_iow_n), 1);
        check("R1 done", int'(done), 0);
        check("R1 claimed", int'(claimed), 0);
        check("R1 rd_data", int'(rd_data), 0);
    endtask

    task automatic t_compat();
        tim_reg = 16'h8000 | 16'h3000 | 16'h0300;
        dev_rdata = 16'hA5C3;
        run(4'h0, 1'b0, 1'b0, 16'h0, 0);
        check("R2 width", m_width, 5);
        check("R2 recovery", m_rec, 4);
        check("R9 rdata", m_rdata, 16'hA5C3);
        check("R10 claimed", m_claim, 1);
        check("R9 other strobe", m_other, 0);
    endtask

    task automatic t_fast();
        tim_reg = 16'h8000 | (16'd2 << 12) | (16'd3 << 8) | 16'h0001;
        run(4'h0, 1'b0, 1'b0, 16'h0, 0);
        check("R3 width code10", m_width, 3);
        check("R3 recovery code11", m_rec, 1);
        tim_reg = 16'h8000 | (16'd3 << 12) | (16'd1 << 8) | 16'h0001;
        run(4'h0, 1'b0, 1'b0, 16'h0, 0);
        check("R3 width reserved", m_width, 5);
        check("R3 recovery code01", m_rec, 3);
        tim_reg = 16'h8000 | (16'd1 << 12) | (16'd2 << 8) | 16'h0001;
        run(4'h0, 1'b0, 1'b0, 16'h0, 0);
        check("R3 width code01", m_width, 4);
        check("R3 recovery code10", m_rec, 2);
    endtask

    task automatic t_slave();
        slv_tim = 4'b1011;
        tim_reg = 16'h8000 | (16'd1 << 12) | (16'd0 << 8) | 16'h0010;
        run(4'h0, 1'b0, 1'b1, 16'h0, 0);
        check("R4 shared width", m_width, 4);
        check("R4 shared recovery", m_rec, 4);
        tim_reg = tim_reg | 16'h4000;
        run(4'h0, 1'b0, 1'b1, 16'h0, 0);
        check("R4 slave width", m_width, 3);
        check("R4 slave recovery", m_rec, 1);
        run(4'h0, 1'b0, 1'b0, 16'h0, 0);
        check("R4 drive0 compat width", m_width, 5);
    endtask

    task automatic t_dma_only();
        tim_reg = 16'h8000 | (16'd2 << 12) | (16'd3 << 8) | 16'h0009;
        run(4'h0, 1'b0, 1'b0, 16'h0, 0);
        check("R5 drive0 width", m_width, 5);
        check("R5 drive0 recovery", m_rec, 4);
        tim_reg = 16'h8000 | (16'd2 << 12) | (16'd3 << 8) | 16'h0090;
        run(4'h0, 1'b0, 1'b1, 16'h0, 0);
        check("R5 drive1 width", m_width, 5);
    endtask

    task automatic t_non_data();
        tim_reg = 16'h8000 | (16'd2 << 12) | (16'd3 << 8) | 16'h0001;
        run(4'h7, 1'b0, 1'b0, 16'h0, 0);
        check("R6 command width", m_width, 5);
        check("R6 command recovery", m_rec, 4);
        run(4'hE, 1'b0, 1'b0, 16'h0, 0);
        check("R6 control width", m_width, 5);
    endtask

    task automatic t_iordy();
        tim_reg = 16'h8000 | (16'd2 << 12) | (16'd3 << 8) | 16'h0003;
        run(4'h0, 1'b0, 1'b0, 16'h0, 6);
        check("R7 wait width", m_width, 6);
        check("R7 wait recovery", m_rec, 1);
        tim_reg = 16'h8000 | (16'd2 << 12) | (16'd3 << 8) | 16'h0001;
        run(4'h0, 1'b0, 1'b0, 16'h0, 50);
        check("R7 ignored width", m_width, 3);
        tim_reg = 16'h8000 | 16'h0020;
        run(4'h0, 1'b0, 1'b1, 16'h0, 8);
        check("R7 drive1 wait width", m_width, 8);
    endtask

    task automatic t_disabled();
        tim_reg = 16'h0001;
        run(4'h0, 1'b0, 1'b0, 16'h0, 0);
        check("R8 no strobe", m_width, 0);
        check("R8 not claimed", m_claim, 0);
        check("R8 done latency", m_rec, 0);
    endtask

    task automatic t_write();
        tim_reg = 16'h8000 | (16'd1 << 12) | (16'd1 << 8) | 16'h0001;
        run(4'h0, 1'b1, 1'b0, 16'h5AF0, 0);
        check("R9 write width", m_width, 4);
        check("R9 write recovery", m_rec, 3);
        check("R9 wdata", m_wdata, 16'h5AF0);
        check("R9 addr", m_addr, 0);
        check("R9 no read strobe", m_other, 0);
        check("R10 write claimed", m_claim, 1);
        run(4'hB, 1'b1, 1'b1, 16'h1234, 0);
        check("R9 addr control", m_addr, 11);
        check("R9 wdata2", m_wdata, 16'h1234);
    endtask

    initial begin
        #(8 * 200000);
        check("watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_compat();
        t_fast();
        t_slave();
        t_dma_only();
        t_non_data();
        t_iordy();
        t_disabled();
        t_write();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule